// File: doc/BRIEF.md
# Accumulator ALU with condition codes

This block is the arithmetic and logic unit of a small accumulator processor with an 8-bit data path. Each cycle it is offered an operation code, a byte-wide accumulator operand, the 16-bit double accumulator (high byte A, low byte B), a 16-bit memory operand, a 16-bit index value and the current condition-code byte. The byte-wide operations use the low byte of the memory operand. The 16-bit operations are double-accumulator add and compare, an unsigned 8x8 multiply of A by B, and an unsigned add of B into the index value.

Every operation has its own flag rule. Some flags are computed from the result, some are forced to a constant, and the rest pass through from the incoming condition-code byte. A registered stage captures the result, the new condition-code byte and a write-enable on every cycle where the valid strobe is high, and holds them otherwise. The write-enable is low for operations that affect only the flags. The caller selects whether A or B is the byte operand, so the block never decodes registers.

Top module: `cc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_q`, `cc_q` and `we_q` become 0. Within any condition-code byte, C is bit 0, V is bit 1, Z is bit 2, N is bit 3 and H is bit 5. Bits 4, 6 and 7 always pass through from `cc_in`. Z always means the written result is zero, and N always means the result's top bit.
- R2: The outputs load one clock after an edge where `in_valid` is high. While `in_valid` is low they hold their values.
- R3: ADD (op 0) gives acc+mem, and ADC (op 1) gives acc+mem+C. Both set H to the carry out of bit 3, C to the carry out of bit 7 and V on signed overflow, and set N and Z from the result.
- R4: SUB (op 2) and CMP (op 3) give acc-mem. C is set when mem is greater than acc (unsigned), V is set on signed overflow, N and Z follow the result, and H is unchanged. CMP presents the difference but gives `we_q`=0.
- R5: AND (op 4), BIT (op 5), OR (op 6), EOR (op 7) and LD (op 8, result = mem) set N and Z and force V=0, leaving C and H unchanged. BIT presents acc AND mem with `we_q`=0.
- R6: CLR (op 9) gives 0 with N=0, Z=1, V=0, C=0. COM (op 10) gives ~acc, sets N and Z, and forces V=0 and C=1. Both leave H unchanged.
- R7: NEG (op 11) gives 0-acc. C is set when acc is nonzero, V is set when acc is 0x80, N and Z follow the result, and H is unchanged.
- R8: INC (op 12) and DEC (op 13) set N and Z. V is set when INC starts from 0x7F or DEC starts from 0x80. C and H are unchanged.
- R9: LSR (op 14) shifts right with a 0 into bit 7, so N=0. ASR (op 15) shifts right and keeps bit 7. Both move bit 0 into C and leave V unchanged. ASL (op 16) shifts left with a 0 into bit 0, moves bit 7 into C and sets V to bit 7 XOR bit 6. All three set Z, and ASR and ASL set N.
- R10: ADDD (op 17) gives dacc+mem, and CMPD (op 18) gives dacc-mem with C as the borrow. Both set N, Z and V on 16 bits and leave H unchanged. CMPD gives `we_q`=0.
- R11: MUL (op 19) gives the unsigned product dacc[15:8]*dacc[7:0]. Z is set from all 16 bits, C equals product bit 7, and the other flags are unchanged.
- R12: ABX (op 20) gives xreg + zero-extended dacc[7:0] modulo 2^16, and `cc_q` equals `cc_in`.
- R13: Byte results are zero-extended into `res_q`. Any op code from 21 to 31 gives result 0, `cc_q`=`cc_in` and `we_q`=0. All other defined ops give `we_q`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that loads the output stage |
| op | input | 5 | Operation code |
| acc | input | 8 | Byte accumulator operand |
| dacc | input | 16 | Double accumulator, A in high byte, B in low byte |
| mem | input | 16 | Memory operand; byte ops use bits 7:0 |
| xreg | input | 16 | Index value for ABX |
| cc_in | input | 8 | Current condition-code byte |
| res_q | output | 16 | Registered result |
| cc_q | output | 8 | Registered condition-code byte |
| we_q | output | 1 | Registered result write-enable |

## Verification
The assertions check several things on every cycle: the hold behaviour while the strobe is low, the forced flags of CLR, the logical group and LSR, the preserved carry of INC and DEC, and the untouched flags of ABX. They also check that the flag-only operations never raise the write-enable, and that Z after MUL matches the whole product. Only the bench's scenarios can show the exact arithmetic results. The same holds for the half-carry, borrow and overflow flags at their boundary values (0x7F, 0x80, 0x00, 0xFF and 16-bit wrap), the product's bit-7 carry and the handling of undefined op codes.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  localparam int CC_W = 8;
  localparam int OP_W = 5;
  localparam int FC = 0;
  localparam int FV = 1;
  localparam int FZ = 2;
  localparam int FN = 3;
  localparam int FH = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_CMP  = 5'd3,
    OP_AND  = 5'd4,  OP_BIT  = 5'd5,  OP_OR   = 5'd6,  OP_EOR  = 5'd7,
    OP_LD   = 5'd8,  OP_CLR  = 5'd9,  OP_COM  = 5'd10, OP_NEG  = 5'd11,
    OP_INC  = 5'd12, OP_DEC  = 5'd13, OP_LSR  = 5'd14, OP_ASR  = 5'd15,
    OP_ASL  = 5'd16, OP_ADDD = 5'd17, OP_CMPD = 5'd18, OP_MUL  = 5'd19,
    OP_ABX  = 5'd20
  } alu_op_e;
endpackage

// File: rtl/cc_alu_byte.sv
module cc_alu_byte
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    acc,
  input  logic [W-1:0]    mem,
  input  logic [CC_W-1:0] cc_in,
  output logic [W-1:0]    res,
  output logic [CC_W-1:0] cc_out,
  output logic            we,
  output logic            hit
);
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS  = ~TOP_ONLY;

  logic         cin;
  logic [W:0]   sum;
  logic [W:0]   dif;
  logic [4:0]   nib;
  logic         setnz;

  always_comb begin
    cin = (op == OP_ADC) ? cc_in[FC] : 1'b0;
    sum = {1'b0, acc} + {1'b0, mem} + {{W{1'b0}}, cin};
    dif = {1'b0, acc} - {1'b0, mem};
    nib = {1'b0, acc[3:0]} + {1'b0, mem[3:0]} + {4'b0, cin};
  end

  always_comb begin
    res    = '0;
    cc_out = cc_in;
    we     = 1'b1;
    hit    = 1'b1;
    setnz  = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        res        = sum[W-1:0];
        cc_out[FH] = nib[4];
        cc_out[FC] = sum[W];
        cc_out[FV] = (acc[W-1] == mem[W-1]) && (sum[W-1] != acc[W-1]);
      end
      OP_SUB, OP_CMP: begin
        res        = dif[W-1:0];
        cc_out[FC] = dif[W];
        cc_out[FV] = (acc[W-1] != mem[W-1]) && (dif[W-1] != acc[W-1]);
        we         = (op == OP_SUB);
      end
      OP_AND, OP_BIT: begin
        res        = acc & mem;
        cc_out[FV] = 1'b0;
        we         = (op == OP_AND);
      end
      OP_OR: begin
        res        = acc | mem;
        cc_out[FV] = 1'b0;
      end
      OP_EOR: begin
        res        = acc ^ mem;
        cc_out[FV] = 1'b0;
      end
      OP_LD: begin
        res        = mem;
        cc_out[FV] = 1'b0;
      end
      OP_CLR: begin
        res        = '0;
        cc_out[FV] = 1'b0;
        cc_out[FC] = 1'b0;
      end
      OP_COM: begin
        res        = ~acc;
        cc_out[FV] = 1'b0;
        cc_out[FC] = 1'b1;
      end
      OP_NEG: begin
        res        = '0 - acc;
        cc_out[FC] = (acc != '0);
        cc_out[FV] = (acc == TOP_ONLY);
      end
      OP_INC: begin
        res        = acc + {{(W-1){1'b0}}, 1'b1};
        cc_out[FV] = (acc == MAX_POS);
      end
      OP_DEC: begin
        res        = acc - {{(W-1){1'b0}}, 1'b1};
        cc_out[FV] = (acc == TOP_ONLY);
      end
      OP_LSR: begin
        res        = {1'b0, acc[W-1:1]};
        cc_out[FC] = acc[0];
      end
      OP_ASR: begin
        res        = {acc[W-1], acc[W-1:1]};
        cc_out[FC] = acc[0];
      end
      OP_ASL: begin
        res        = {acc[W-2:0], 1'b0};
        cc_out[FC] = acc[W-1];
        cc_out[FV] = acc[W-1] ^ acc[W-2];
      end
      default: begin
        hit   = 1'b0;
        we    = 1'b0;
        setnz = 1'b0;
      end
    endcase
    if (setnz) begin
      cc_out[FN] = res[W-1];
      cc_out[FZ] = (res == '0);
    end
  end
endmodule

// File: rtl/cc_alu_word.sv
module cc_alu_word
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e         op,
  input  logic [2*W-1:0]  dacc,
  input  logic [2*W-1:0]  mem,
  input  logic [2*W-1:0]  xreg,
  input  logic [CC_W-1:0] cc_in,
  output logic [2*W-1:0]  res,
  output logic [CC_W-1:0] cc_out,
  output logic            we
);
  localparam int DW = 2 * W;

  logic [DW:0]   sum;
  logic [DW:0]   dif;
  logic [DW-1:0] prod;
  logic [DW-1:0] idx;

  always_comb begin
    sum  = {1'b0, dacc} + {1'b0, mem};
    dif  = {1'b0, dacc} - {1'b0, mem};
    prod = {{W{1'b0}}, dacc[DW-1:W]} * {{W{1'b0}}, dacc[W-1:0]};
    idx  = xreg + {{W{1'b0}}, dacc[W-1:0]};
  end

  always_comb begin
    res    = '0;
    cc_out = cc_in;
    we     = 1'b1;
    case (op)
      OP_ADDD: begin
        res        = sum[DW-1:0];
        cc_out[FC] = sum[DW];
        cc_out[FV] = (dacc[DW-1] == mem[DW-1]) && (sum[DW-1] != dacc[DW-1]);
        cc_out[FN] = sum[DW-1];
        cc_out[FZ] = (sum[DW-1:0] == '0);
      end
      OP_CMPD: begin
        res        = dif[DW-1:0];
        cc_out[FC] = dif[DW];
        cc_out[FV] = (dacc[DW-1] != mem[DW-1]) && (dif[DW-1] != dacc[DW-1]);
        cc_out[FN] = dif[DW-1];
        cc_out[FZ] = (dif[DW-1:0] == '0);
        we         = 1'b0;
      end
      OP_MUL: begin
        res        = prod;
        cc_out[FC] = prod[W-1];
        cc_out[FZ] = (prod == '0);
      end
      OP_ABX: begin
        res = idx;
      end
      default: we = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_alu_oreg.sv
module cc_alu_oreg
  import cc_alu_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [RW-1:0]   res_d,
  input  logic [CC_W-1:0] cc_d,
  input  logic            we_d,
  output logic [RW-1:0]   res_q,
  output logic [CC_W-1:0] cc_q,
  output logic            we_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      cc_q  <= '0;
      we_q  <= 1'b0;
    end else if (load) begin
      res_q <= res_d;
      cc_q  <= cc_d;
      we_q  <= we_d;
    end
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    acc,
  input  logic [2*W-1:0]  dacc,
  input  logic [2*W-1:0]  mem,
  input  logic [2*W-1:0]  xreg,
  input  logic [CC_W-1:0] cc_in,
  output logic [2*W-1:0]  res_q,
  output logic [CC_W-1:0] cc_q,
  output logic            we_q
);
  localparam int DW = 2 * W;

  alu_op_e         op_e;
  logic [W-1:0]    b_res;
  logic [CC_W-1:0] b_cc;
  logic            b_we;
  logic            b_hit;
  logic [DW-1:0]   w_res;
  logic [CC_W-1:0] w_cc;
  logic            w_we;
  logic [DW-1:0]   res_d;
  logic [CC_W-1:0] cc_d;
  logic            we_d;

  assign op_e = alu_op_e'(op);

  cc_alu_byte #(.W(W)) u_byte (
    .op(op_e), .acc(acc), .mem(mem[W-1:0]), .cc_in(cc_in),
    .res(b_res), .cc_out(b_cc), .we(b_we), .hit(b_hit)
  );

  cc_alu_word #(.W(W)) u_word (
    .op(op_e), .dacc(dacc), .mem(mem), .xreg(xreg), .cc_in(cc_in),
    .res(w_res), .cc_out(w_cc), .we(w_we)
  );

  always_comb begin
    if (b_hit) begin
      res_d = {{W{1'b0}}, b_res};
      cc_d  = b_cc;
      we_d  = b_we;
    end else begin
      res_d = w_res;
      cc_d  = w_cc;
      we_d  = w_we;
    end
  end

  cc_alu_oreg #(.RW(DW)) u_oreg (
    .clk(clk), .rst(rst), .load(in_valid),
    .res_d(res_d), .cc_d(cc_d), .we_d(we_d),
    .res_q(res_q), .cc_q(cc_q), .we_q(we_q)
  );
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [OP_W-1:0] op,
  input logic [CC_W-1:0] cc_in,
  input logic [2*W-1:0]  res_q,
  input logic [CC_W-1:0] cc_q,
  input logic            we_q
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_q) && $stable(cc_q) && $stable(we_q)));

  assert_logic_v_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 5'd4 && op <= 5'd8) |=> !cc_q[FV]);

  assert_clr_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 5'd9) |=>
      (res_q == '0 && cc_q[FZ] && !cc_q[FN] && !cc_q[FV] && !cc_q[FC]));

  assert_incdec_c_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 5'd12 || op == 5'd13)) |=> (cc_q[FC] == $past(cc_in[FC])));

  assert_lsr_n_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 5'd14) |=> !cc_q[FN]);

  assert_mul_z_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 5'd19) |=> (cc_q[FZ] == (res_q == '0)));

  assert_abx_cc_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 5'd20) |=> (cc_q == $past(cc_in)));

  assert_flag_only_R13: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 5'd3 || op == 5'd5 || op == 5'd18 || op > 5'd20)) |=> !we_q);
endmodule

bind cc_alu cc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .cc_in(cc_in),
  .res_q(res_q), .cc_q(cc_q), .we_q(we_q)
);

// File: tb/cc_alu_test.sv
`timescale 1ns/1ps
module cc_alu_test;
  typedef struct packed {
    logic [4:0]  op;
    logic [7:0]  acc;
    logic [15:0] dacc;
    logic [15:0] mem;
    logic [15:0] x;
    logic [7:0]  cc;
    logic [15:0] eres;
    logic [7:0]  ecc;
    logic        ewe;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    // R3 ADD overflow into sign, half carry
    {5'd0,  8'h7F, 16'h0000, 16'h0001, 16'h0000, 8'h00, 16'h0080, 8'h2A, 1'b1, 4'd3},
    // R3 ADC carry in wraps to zero
    {5'd1,  8'hFF, 16'h0000, 16'h0000, 16'h0000, 8'h01, 16'h0000, 8'h25, 1'b1, 4'd3},
    // R4 SUB borrow, H kept
    {5'd2,  8'h10, 16'h0000, 16'h0020, 16'h0000, 8'h20, 16'h00F0, 8'h29, 1'b1, 4'd4},
    // R4 CMP signed overflow, no write
    {5'd3,  8'h80, 16'h0000, 16'h0001, 16'h0000, 8'h00, 16'h007F, 8'h02, 1'b0, 4'd4},
    // R4 SUB 0 - 1
    {5'd2,  8'h00, 16'h0000, 16'h0001, 16'h0000, 8'h00, 16'h00FF, 8'h09, 1'b1, 4'd4},
    // R5 AND zero, V cleared, C kept
    {5'd4,  8'hF0, 16'h0000, 16'h000F, 16'h0000, 8'h03, 16'h0000, 8'h05, 1'b1, 4'd5},
    // R5 BIT no write
    {5'd5,  8'h81, 16'h0000, 16'h0080, 16'h0000, 8'h02, 16'h0080, 8'h08, 1'b0, 4'd5},
    // R5 LD zero
    {5'd8,  8'h55, 16'h0000, 16'h0000, 16'h0000, 8'h0A, 16'h0000, 8'h04, 1'b1, 4'd5},
    // R5 EOR
    {5'd7,  8'hAA, 16'h0000, 16'h00FF, 16'h0000, 8'h01, 16'h0055, 8'h01, 1'b1, 4'd5},
    // R5 OR
    {5'd6,  8'h80, 16'h0000, 16'h0001, 16'h0000, 8'h00, 16'h0081, 8'h08, 1'b1, 4'd5},
    // R6 CLR, upper bits pass through
    {5'd9,  8'h12, 16'h0000, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 8'hF4, 1'b1, 4'd6},
    // R6 COM
    {5'd10, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h00FF, 8'h09, 1'b1, 4'd6},
    // R7 NEG of 0x80
    {5'd11, 8'h80, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h0080, 8'h0B, 1'b1, 4'd7},
    // R7 NEG of zero
    {5'd11, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h0F, 16'h0000, 8'h04, 1'b1, 4'd7},
    // R8 INC 0x7F keeps C
    {5'd12, 8'h7F, 16'h0000, 16'h0000, 16'h0000, 8'h01, 16'h0080, 8'h0B, 1'b1, 4'd8},
    // R8 DEC to zero
    {5'd13, 8'h01, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h04, 1'b1, 4'd8},
    // R8 DEC 0x80
    {5'd13, 8'h80, 16'h0000, 16'h0000, 16'h0000, 8'h01, 16'h007F, 8'h03, 1'b1, 4'd8},
    // R9 LSR
    {5'd14, 8'h81, 16'h0000, 16'h0000, 16'h0000, 8'h0A, 16'h0040, 8'h03, 1'b1, 4'd9},
    // R9 ASR
    {5'd15, 8'h81, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h00C0, 8'h09, 1'b1, 4'd9},
    // R9 ASL
    {5'd16, 8'h40, 16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h0080, 8'h0A, 1'b1, 4'd9},
    // R10 ADDD overflow, H kept
    {5'd17, 8'h00, 16'h7FFF, 16'h0001, 16'h0000, 8'h20, 16'h8000, 8'h2A, 1'b1, 4'd10},
    // R10 ADDD wrap
    {5'd17, 8'h00, 16'hFFFF, 16'h0001, 16'h0000, 8'h00, 16'h0000, 8'h05, 1'b1, 4'd10},
    // R10 CMPD borrow
    {5'd18, 8'h00, 16'h1000, 16'h2000, 16'h0000, 8'h00, 16'hF000, 8'h09, 1'b0, 4'd10},
    // R11 MUL 255*255
    {5'd19, 8'h00, 16'hFFFF, 16'h0000, 16'h0000, 8'h0F, 16'hFE01, 8'h0A, 1'b1, 4'd11},
    // R11 MUL 12*11, bit 7 set
    {5'd19, 8'h00, 16'h0C0B, 16'h0000, 16'h0000, 8'h00, 16'h0084, 8'h01, 1'b1, 4'd11},
    // R11 MUL by zero
    {5'd19, 8'h00, 16'h0055, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h04, 1'b1, 4'd11},
    // R12 ABX
    {5'd20, 8'h00, 16'h1220, 16'h0000, 16'h10F0, 8'h2F, 16'h1110, 8'h2F, 1'b1, 4'd12},
    // R12 ABX wrap
    {5'd20, 8'h00, 16'h0001, 16'h0000, 16'hFFFF, 8'h00, 16'h0000, 8'h00, 1'b1, 4'd12},
    // R13 undefined op
    {5'd31, 8'hAA, 16'h1234, 16'h5678, 16'h9ABC, 8'h3C, 16'h0000, 8'h3C, 1'b0, 4'd13}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  acc = '0;
  logic [15:0] dacc = '0;
  logic [15:0] mem = '0;
  logic [15:0] xreg = '0;
  logic [7:0]  cc_in = '0;
  logic [15:0] res_q;
  logic [7:0]  cc_q;
  logic        we_q;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cc_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .acc(acc),
    .dacc(dacc), .mem(mem), .xreg(xreg), .cc_in(cc_in),
    .res_q(res_q), .cc_q(cc_q), .we_q(we_q)
  );

  task automatic check(input string tag, input logic [15:0] er,
                       input logic [7:0] ec, input logic ew);
    checks++;
    if (res_q !== er || cc_q !== ec || we_q !== ew) begin
      fails++;
      $display("FAIL %s: res=%h cc=%h we=%b expected res=%h cc=%h we=%b",
               tag, res_q, cc_q, we_q, er, ec, ew);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 16'h0000, 8'h00, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op = VEC[i].op; acc = VEC[i].acc; dacc = VEC[i].dacc;
      mem = VEC[i].mem; xreg = VEC[i].x; cc_in = VEC[i].cc;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            VEC[i].eres, VEC[i].ecc, VEC[i].ewe);
    end

    // R2: load an ADD, then change inputs with the strobe low
    @(negedge clk);
    op = 5'd0; acc = 8'h01; mem = 16'h0002; cc_in = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 load", 16'h0003, 8'h00, 1'b1);
    op = 5'd9; acc = 8'hFF; cc_in = 8'hFF;
    repeat (3) @(negedge clk);
    check("R2 hold while strobe low", 16'h0003, 8'h00, 1'b1);

    // R1: synchronous reset after activity
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset after activity", 16'h0000, 8'h00, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 stays cleared", 16'h0000, 8'h00, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule